// File: doc/BRIEF.md
# Dual Retriggerable Gated One-Shot

This block holds two independent pulse generators that run from one clock. Each channel watches three inputs: an active-low gate, an active-high gate and an active-low clear. When a qualifying edge appears on them, the channel drives its output high for a programmed number of clock cycles and drives a complementary output low for the same time. The pulse length comes from a per-channel duration register, which is written through a simple write strobe and data bus.

A qualifying edge that arrives while a pulse is already running reloads the full duration, so a steady stream of triggers keeps the output high. Taking the clear input low ends the pulse and blocks new triggers. Bringing the clear input back high while both gates sit in their enabling state starts a pulse. Every input passes through a two-flop synchronizer, so the inputs may be asynchronous to the clock.

Top module: `dual_oneshot`

## Requirements
- R1: After reset both channels show pulseQ low and pulseQn high. No pulse appears unless a qualifying edge is applied after reset, and this holds even when the inputs sit at gateLowN=0, gateHigh=1, clearN=1 during and after reset.
- R2: With gateLowN low and clearN high, a low-to-high change on gateHigh starts a pulse. A low-to-high change on gateHigh while gateLowN is high starts nothing.
- R3: With gateHigh high and clearN high, a high-to-low change on gateLowN starts a pulse. A high-to-low change on gateLowN while gateHigh is low starts nothing.
- R4: With gateLowN low and gateHigh high, a low-to-high change on clearN starts a pulse.
- R5: An input change made between clock edges shows on pulseQ after the third following rising edge: two synchronizer stages plus the counter register. pulseQ then stays high for exactly D consecutive cycles, where D is the channel's duration register.
- R6: A qualifying edge during a running pulse reloads the counter with D, so the pulse ends D cycles after the reload. This also holds when the reload falls in the cycle in which the counter would have expired.
- R7: Once the synchronized clearN is low, pulseQ is low in that cycle, and the count is zeroed at the next edge. Gate edges that occur while clearN is low start no pulse.
- R8: A channel whose duration register holds zero produces no pulse when triggered.
- R9: The channels are independent: activity on one channel's inputs and writes to its duration register have no effect on the other channel's outputs.
- R10: pulseQn is the exact complement of pulseQ in every cycle.
- R11: durWe[i] high at a rising edge loads durData into channel i's duration register. The register resets to DUR_RESET, and the value it holds when a pulse is triggered sets that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateLowN | input | NUM_CH | Active-low gate input per channel |
| gateHigh | input | NUM_CH | Active-high gate input per channel |
| clearN | input | NUM_CH | Active-low clear per channel |
| durWe | input | NUM_CH | Duration register write strobe per channel |
| durData | input | DUR_W | Duration value, shared by both channels |
| pulseQ | output | NUM_CH | Pulse output per channel |
| pulseQn | output | NUM_CH | Complement of pulseQ per channel |

## Verification
The bench sweeps every duration of a 4-bit register through all three start methods on both channels. For each run it checks the latency, the exact pulse length and that exactly one rising edge occurs. An off-by-one counter would stretch or shorten every pulse, and a wrong duration of zero would emit a one-cycle pulse. The bench places a retrigger exactly on the expiry cycle, where a design that favours expiry would drop the output for a cycle and show two rising edges. It applies gate edges under clear and holds enabling levels through reset, which a design without edge suppression or warm-up gating would answer with a spurious pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Strobes from the control part to the counting datapath
  typedef struct packed {
    logic load;   // reload the counter with the duration
    logic clear;  // synchronized clear is active
  } strobe_t;
endpackage

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    gateLowN,
  input  logic    gateHigh,
  input  logic    clearN,
  output strobe_t strobe
);
  localparam int SYNC_DEPTH = 2;
  localparam logic [1:0] WARM_DONE = 2'd3;

  logic [SYNC_DEPTH-1:0] syncA, syncB, syncC;
  logic prevA, prevB, prevC;
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '0;
      syncC <= '1;
      prevA <= 1'b1;
      prevB <= 1'b0;
      prevC <= 1'b1;
      warm  <= '0;
    end else begin
      syncA <= {syncA[SYNC_DEPTH-2:0], gateLowN};
      syncB <= {syncB[SYNC_DEPTH-2:0], gateHigh};
      syncC <= {syncC[SYNC_DEPTH-2:0], clearN};
      prevA <= syncA[SYNC_DEPTH-1];
      prevB <= syncB[SYNC_DEPTH-1];
      prevC <= syncC[SYNC_DEPTH-1];
      if (warm != WARM_DONE) warm <= warm + 2'd1;
    end
  end

  logic aS, bS, cS, armed, fallA, riseB, riseC, enabled;

  always_comb begin
    aS      = syncA[SYNC_DEPTH-1];
    bS      = syncB[SYNC_DEPTH-1];
    cS      = syncC[SYNC_DEPTH-1];
    armed   = (warm == WARM_DONE);
    fallA   = prevA & ~aS;
    riseB   = ~prevB & bS;
    riseC   = ~prevC & cS;
    enabled = cS & ~aS & bS;
    strobe.load  = armed & enabled & (fallA | riseB | riseC);
    strobe.clear = ~cS;
  end
endmodule

// File: rtl/oneshot_count.sv
module oneshot_count
  import oneshot_pkg::*;
#(
  parameter int DUR_W     = 8,
  parameter int DUR_RESET = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             durWe,
  input  logic [DUR_W-1:0] durData,
  output logic             q,
  output logic             qN
);
  logic [DUR_W-1:0] durReg;
  logic [DUR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      durReg <= DUR_W'(DUR_RESET);
    else if (durWe) durReg <= durData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.clear) cnt <= '0;
    else if (strobe.load)  cnt <= durReg;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign q  = (cnt != '0) & ~strobe.clear;
  assign qN = ~q;

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> cnt == '0);
  // R6
  reload_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.clear |=> cnt == $past(durReg));
  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0 && !strobe.load && !strobe.clear |=> cnt == $past(cnt) - 1'b1);
  // R8
  zero_dur_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && durReg == '0 |=> !q);
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
  import oneshot_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int DUR_W     = 8,
  parameter int DUR_RESET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] gateLowN,
  input  logic [NUM_CH-1:0] gateHigh,
  input  logic [NUM_CH-1:0] clearN,
  input  logic [NUM_CH-1:0] durWe,
  input  logic [DUR_W-1:0]  durData,
  output logic [NUM_CH-1:0] pulseQ,
  output logic [NUM_CH-1:0] pulseQn
);
  strobe_t strobeCh [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    oneshot_ctrl uCtrl (
      .clk      (clk),
      .rstN     (rstN),
      .gateLowN (gateLowN[i]),
      .gateHigh (gateHigh[i]),
      .clearN   (clearN[i]),
      .strobe   (strobeCh[i])
    );

    oneshot_count #(.DUR_W(DUR_W), .DUR_RESET(DUR_RESET)) uCount (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobeCh[i]),
      .durWe   (durWe[i]),
      .durData (durData),
      .q       (pulseQ[i]),
      .qN      (pulseQn[i])
    );

    // R2
    rise_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pulseQ[i]) |-> $past(strobeCh[i].load));
  end
endmodule

// File: tb/tb_dual_oneshot.sv
module tb_dual_oneshot;
  localparam int NCH = 2;
  localparam int DW  = 4;
  localparam int DRST = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] gateLowN, gateHigh, clearN, durWe;
  logic [DW-1:0] durData;
  logic [NCH-1:0] pulseQ, pulseQn;

  int checks = 0, fails = 0, qnBad = 0;
  bit done = 1'b0;
  int obsLen [NCH];
  int obsFirst [NCH];
  int obsRise [NCH];

  always #2.5 clk = ~clk;

  dual_oneshot #(.NUM_CH(NCH), .DUR_W(DW), .DUR_RESET(DRST)) dut (
    .clk(clk), .rstN(rstN), .gateLowN(gateLowN), .gateHigh(gateHigh),
    .clearN(clearN), .durWe(durWe), .durData(durData),
    .pulseQ(pulseQ), .pulseQn(pulseQn));

  // R10 monitor
  always @(negedge clk) begin
    if (rstN && pulseQn !== ~pulseQ) qnBad++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic observe(input int n);
    bit prev [NCH];
    for (int c = 0; c < NCH; c++) begin
      obsLen[c] = 0; obsFirst[c] = 0; obsRise[c] = 0; prev[c] = pulseQ[c];
    end
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (pulseQ[c]) begin
          obsLen[c]++;
          if (obsFirst[c] == 0) obsFirst[c] = i;
          if (!prev[c]) obsRise[c]++;
        end
        prev[c] = pulseQ[c];
      end
    end
  endtask

  task automatic idleAll();
    gateLowN = '1; gateHigh = '0; clearN = '1;
  endtask

  task automatic setDur(input int ch, input int d);
    @(negedge clk);
    durWe = '0; durWe[ch] = 1'b1; durData = DW'(d);
    @(negedge clk);
    durWe = '0;
  endtask

  // one start by method m on channel ch with duration d
  task automatic trial(input int ch, input int m, input int d);
    int oc;
    string tg;
    oc = 1 - ch;
    tg = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
    setDur(ch, d);                              // R11
    if (m == 0) begin
      gateLowN[ch] = 1'b0;                     // fall with gateHigh low
      observe(4); chk(obsLen[ch] == 0, "R3 no start gateHigh low", obsLen[ch], 0);
      gateHigh[ch] = 1'b1;
    end else if (m == 1) begin
      gateHigh[ch] = 1'b1;                     // rise with gateLowN high
      observe(4); chk(obsLen[ch] == 0, "R2 no start gateLowN high", obsLen[ch], 0);
      gateLowN[ch] = 1'b0;
    end else begin
      clearN[ch] = 1'b0;
      observe(4);
      gateLowN[ch] = 1'b0; gateHigh[ch] = 1'b1;
      observe(4); chk(obsLen[ch] == 0, "R7 edges under clear", obsLen[ch], 0);
      clearN[ch] = 1'b1;
    end
    observe(d + 6);
    chk(obsLen[ch] == d, {tg, " R5 R8 length"}, obsLen[ch], d);
    chk(obsFirst[ch] == ((d != 0) ? 3 : 0), {tg, " R5 latency"}, obsFirst[ch], (d != 0) ? 3 : 0);
    chk(obsRise[ch] == ((d != 0) ? 1 : 0), {tg, " single pulse"}, obsRise[ch], (d != 0) ? 1 : 0);
    chk(obsLen[oc] == 0, "R9 other channel quiet", obsLen[oc], 0);
    idleAll();
    observe(3);
  endtask

  initial begin
    gateLowN = '0; gateHigh = '1; clearN = '1; durWe = '0; durData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: enabling levels held through reset, no pulse expected
    @(negedge clk);
    chk(pulseQ == '0, "R1 Q low after reset", pulseQ, 0);
    chk(pulseQn == '1, "R1 Qn high after reset", pulseQn, 3);
    observe(12);
    chk(obsLen[0] + obsLen[1] == 0, "R1 no spurious pulse", obsLen[0] + obsLen[1], 0);
    idleAll();
    observe(4);
    // R11: reset duration used; R4 start via clear rise
    clearN[0] = 1'b0; observe(3);
    gateLowN[0] = 1'b0; gateHigh[0] = 1'b1; observe(3);
    clearN[0] = 1'b1; observe(DRST + 6);
    chk(obsLen[0] == DRST, "R11 reset duration", obsLen[0], DRST);
    idleAll(); observe(4);

    // sweep all durations, all methods, both channels
    for (int ch = 0; ch < NCH; ch++)
      for (int m = 0; m < 3; m++)
        for (int d = 0; d < (1 << DW); d++)
          trial(ch, m, d);

    // R6: retrigger 4 cycles after start, duration 6
    setDur(0, 6);
    gateLowN[0] = 1'b0; observe(3);
    gateHigh[0] = 1'b1; observe(2);
    gateHigh[0] = 1'b0; observe(2);
    gateHigh[0] = 1'b1; observe(14);
    // first two samples consumed before last window: total high = 4 + 6
    chk(obsLen[0] == 8 && obsRise[0] == 0, "R6 retrigger extends", obsLen[0], 8);
    idleAll(); observe(4);

    // R6: retrigger landing exactly on the expiry cycle, duration 4
    setDur(0, 4);
    gateLowN[0] = 1'b0; observe(3);
    gateHigh[0] = 1'b1; observe(2);
    gateHigh[0] = 1'b0; observe(2);
    gateHigh[0] = 1'b1; observe(12);
    chk(obsLen[0] == 6 && obsRise[0] == 0, "R6 reload on expiry", obsLen[0], 6);
    idleAll(); observe(4);

    // R7: clear cuts a pulse of 10 after 4 high cycles
    setDur(1, 10);
    gateLowN[1] = 1'b0; observe(3);
    gateHigh[1] = 1'b1; observe(5);
    chk(obsLen[1] == 3, "R7 pulse running", obsLen[1], 3);
    clearN[1] = 1'b0; observe(12);
    chk(obsLen[1] == 1, "R7 clear ends pulse", obsLen[1], 1);
    gateHigh[1] = 1'b0; observe(3);
    gateHigh[1] = 1'b1; observe(3);
    gateHigh[1] = 1'b0; observe(3);
    clearN[1] = 1'b1; observe(14);
    chk(obsLen[1] == 0, "R7 gate edge under clear ignored", obsLen[1], 0);
    idleAll(); observe(4);

    // R9: both channels at once, different durations
    setDur(0, 3); setDur(1, 9);
    gateLowN = '0; observe(3);
    gateHigh = '1; observe(15);
    chk(obsLen[0] == 3, "R9 channel 0 length", obsLen[0], 3);
    chk(obsLen[1] == 9, "R9 channel 1 length", obsLen[1], 9);
    idleAll(); observe(4);

    chk(qnBad == 0, "R10 complement", qnBad, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule